// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the event sources of a serial port's receive and transmit paths into one interrupt request line. It also keeps a 4-bit identification code that software reads to learn which source is being reported. There are four sources. A receive line-status error can come from overrun, parity, framing or break. A receive data-available condition compares the receive FIFO fill count against a selectable trigger level. A character time-out fires when unread data sits idle in the receive FIFO. A transmit holding-empty condition is held back at start-up so that software can fill the FIFO before it is interrupted.

Each source has its own clear rule. A status-register read clears line status. Data-available follows the FIFO count. Any FIFO push or pop ends the time-out. Holding-empty clears on a transmit write, or on an identification read while it is the source being reported. The code register is frozen while an identification read is in progress, so an event that arrives during the read shows up at the next read. The character-time tick comes from the baud logic, one pulse per character time. The serial shifters and the FIFOs are outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: `iir_code` takes only these values: 4'b0001 (nothing pending), 4'b0110 (line status), 4'b0100 (data available), 4'b1100 (character time-out) or 4'b0010 (transmit holding empty). Bit 0 is an active-low pending flag, and `irq` is the inverse of that bit. The value after reset is 4'b0001.
- R2: When more than one enabled source is active, the code reports line status first. Next comes data available, then character time-out. Holding empty comes last.
- R3: `trig_sel` selects the trigger level: 2'b00 selects 1 character, 2'b01 selects 4, 2'b10 selects 8 and 2'b11 selects 14. Data available is active while `rx_count` is at or above the selected level, and inactive while it is below.
- R4: A pulse on any bit of `rx_err` sets the line-status source. The bits are bit 0 overrun, bit 1 parity, bit 2 framing and bit 3 break. A `lsr_read` pulse clears the source; a new error in the same cycle wins over the clear.
- R5: `ien` bit 0 gates both data available and character time-out. Bit 1 gates holding empty, and bit 2 gates line status. A source whose enable bit is 0 is never reported.
- R6: The character time-out source asserts after 4 `char_tick` pulses with `rx_count` non-zero and no `rx_push` or `rx_pop`. Any push or pop, or a zero count, restarts the count and clears the source.
- R7: If a `tx_write` occurred while `tx_empty` was 0 since the last holding-empty event, the holding-empty source sets on the cycle after `tx_empty` rises, without waiting.
- R8: Otherwise a rise of `tx_empty` (including the one after reset) arms a delay. The source sets on the next `char_tick` while the FIFO is still empty, and a `tx_write` cancels the delay.
- R9: The holding-empty source clears on `tx_write`. It also clears on `iir_read` when `iir_code` shows 4'b0010 in that cycle, and on no other read.
- R10: `iir_code` holds its value in every cycle in which `iir_read` is high. It reports the sources present on the first edge after the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien | input | 3 | Source enables: bit 0 receive data/time-out, bit 1 transmit empty, bit 2 line status |
| rx_err | input | 4 | Line-status error pulses: overrun, parity, framing, break |
| rx_count | input | CNT_W (5) | Receive FIFO fill count |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| trig_sel | input | 2 | Receive trigger level select |
| char_tick | input | 1 | One pulse per character time |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_write | input | 1 | Transmit FIFO write strobe |
| iir_read | input | 1 | Identification register read strobe |
| lsr_read | input | 1 | Status register read strobe |
| irq | output | 1 | Interrupt request, high when a source is reported |
| iir_code | output | 4 | Identification code |

## Verification
The identification code is registered. A change in `rx_count`, `ien` or `trig_sel` shows up in `iir_code` one edge after it is applied. A source with its own flag register, such as line status, holding empty or the time-out counter, shows up two edges after its triggering strobe. A clearing strobe likewise takes two edges to remove a source from the code. The bench drives inputs on the falling edge and steps its reference model on the rising edge. It compares `iir_code` and `irq` on every falling edge. Its directed checks wait exactly these one- or two-edge latencies before they sample.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int ERR_W = 4;
   localparam int IEN_W = 3;

   typedef enum logic [3:0] {
      IID_NONE = 4'b0001,
      IID_LINE = 4'b0110,
      IID_DATA = 4'b0100,
      IID_IDLE = 4'b1100,
      IID_TXE  = 4'b0010
   } iid_e;

   localparam int EN_RX = 0;
   localparam int EN_TX = 1;
   localparam int EN_LS = 2;
endpackage

// File: rtl/rx_trig_cmp.sv
module rx_trig_cmp #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5,
   parameter int LVL0  = 1,
   parameter int LVL1  = 4,
   parameter int LVL2  = 8,
   parameter int LVL3  = 14
) (
   input  logic [CNT_W-1:0] rx_count,
   input  logic [1:0]       trig_sel,
   output logic             data_avail
);
   localparam int NLVL = 4;
   localparam int LVLS [NLVL] = '{LVL0, LVL1, LVL2, LVL3};

   if (DEPTH >= (1 << CNT_W)) begin : g_bad_width
      $error("rx_trig_cmp: CNT_W too narrow for DEPTH");
   end

   logic [NLVL-1:0] at_or_above;

   for (genvar i = 0; i < NLVL; i++) begin : g_lvl
      if (LVLS[i] < 1 || LVLS[i] > DEPTH) begin : g_bad_lvl
         $error("rx_trig_cmp: trigger level out of range");
      end
      localparam logic [CNT_W-1:0] LV = CNT_W'(LVLS[i]);
      assign at_or_above[i] = (rx_count >= LV);
   end

   assign data_avail = at_or_above[trig_sel];
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
   parameter int CNT_W    = 5,
   parameter int TO_LIMIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic             char_tick,
   output logic             timeout
);
   if (TO_LIMIT < 1) begin : g_bad_limit
      $error("rx_idle_timer: TO_LIMIT must be at least 1");
   end

   localparam int TW = (TO_LIMIT < 2) ? 1 : $clog2(TO_LIMIT + 1);
   localparam logic [TW-1:0] LIM = TW'(TO_LIMIT);

   logic [TW-1:0] ticks_q;
   logic          restart;

   assign restart = rx_push | rx_pop | (rx_count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks_q <= '0;
      end else if (restart) begin
         ticks_q <= '0;
      end else if (char_tick && ticks_q != LIM) begin
         ticks_q <= ticks_q + 1'b1;
      end
   end

   assign timeout = (ticks_q == LIM);

   assert_activity_clears_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push || rx_pop) |=> !timeout);
   assert_idle_needs_data_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> $past(rx_count) != '0);
endmodule

// File: rtl/tx_empty_tracker.sv
module tx_empty_tracker #(
   parameter int DELAY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_empty,
   input  logic tx_write,
   input  logic char_tick,
   input  logic ack_read,
   output logic pending
);
   if (DELAY < 0) begin : g_bad_delay
      $error("tx_empty_tracker: DELAY must not be negative");
   end

   logic empty_d;
   logic multi_q;
   logic rise;
   logic fire;
   logic clr;

   assign rise = tx_empty & ~empty_d;
   assign clr  = tx_write | ack_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_d <= 1'b0;
         multi_q <= 1'b0;
      end else begin
         empty_d <= tx_empty;
         if (tx_write && !tx_empty) begin
            multi_q <= 1'b1;
         end else if (rise && multi_q) begin
            multi_q <= 1'b0;
         end
      end
   end

   if (DELAY == 0) begin : g_nodelay
      assign fire = rise;
   end else begin : g_delay
      localparam int DW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
      localparam logic [DW-1:0] LAST = DW'(DELAY - 1);
      logic          arm_q;
      logic [DW-1:0] dcnt_q;
      logic          done;

      assign done = arm_q & tx_empty & char_tick & (dcnt_q == LAST);
      assign fire = (rise & multi_q) | done;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            arm_q  <= 1'b0;
            dcnt_q <= '0;
         end else begin
            if (tx_write || !tx_empty) begin
               arm_q <= 1'b0;
            end else if (rise && !multi_q) begin
               arm_q <= 1'b1;
            end else if (done) begin
               arm_q <= 1'b0;
            end
            if (rise) begin
               dcnt_q <= '0;
            end else if (arm_q && char_tick) begin
               dcnt_q <= dcnt_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
      end else begin
         pending <= (pending | fire) & ~clr;
      end
   end

   assert_write_clears_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_write || ack_read) |=> !pending);
   assert_needs_empty_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> $past(tx_empty));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
   import uart_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IEN_W-1:0] ien,
   input  logic             src_line,
   input  logic             src_data,
   input  logic             src_idle,
   input  logic             src_txe,
   input  logic             iir_read,
   output logic [3:0]       iir_code
);
   iid_e nxt;

   always_comb begin
      if (src_line && ien[EN_LS]) begin
         nxt = IID_LINE;
      end else if (src_data && ien[EN_RX]) begin
         nxt = IID_DATA;
      end else if (src_idle && ien[EN_RX]) begin
         nxt = IID_IDLE;
      end else if (src_txe && ien[EN_TX]) begin
         nxt = IID_TXE;
      end else begin
         nxt = IID_NONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iir_code <= IID_NONE;
      end else if (!iir_read) begin
         iir_code <= nxt;
      end
   end

   assert_hold_on_read_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      iir_read |=> $stable(iir_code));
   assert_legal_code_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      iir_code inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010});
   assert_line_first_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!iir_read && src_line && ien[EN_LS]) |=> iir_code == 4'b0110);
   assert_gated_txe_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!iir_read && !ien[EN_TX]) |=> iir_code != 4'b0010);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int CNT_W     = $clog2(DEPTH + 1),
   parameter int TO_LIMIT  = 4,
   parameter int TXE_DELAY = 1,
   parameter int LVL0      = 1,
   parameter int LVL1      = 4,
   parameter int LVL2      = 8,
   parameter int LVL3      = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       ien,
   input  logic [3:0]       rx_err,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic [1:0]       trig_sel,
   input  logic             char_tick,
   input  logic             tx_empty,
   input  logic             tx_write,
   input  logic             iir_read,
   input  logic             lsr_read,
   output logic             irq,
   output logic [3:0]       iir_code
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("uart_irq_ident: DEPTH must be at least 1");
   end

   logic line_q;
   logic data_avail;
   logic idle_to;
   logic txe_pend;
   logic txe_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
      end else begin
         line_q <= (|rx_err) | (line_q & ~lsr_read);
      end
   end

   assert_line_cleared_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_read && rx_err == '0) |=> !line_q);
   assert_line_set_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_err != '0) |=> line_q);

   rx_trig_cmp #(
      .DEPTH(DEPTH), .CNT_W(CNT_W),
      .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
   ) u_trig (
      .rx_count  (rx_count),
      .trig_sel  (trig_sel),
      .data_avail(data_avail)
   );

   rx_idle_timer #(.CNT_W(CNT_W), .TO_LIMIT(TO_LIMIT)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_count (rx_count),
      .rx_push  (rx_push),
      .rx_pop   (rx_pop),
      .char_tick(char_tick),
      .timeout  (idle_to)
   );

   assign txe_ack = iir_read & (iir_code == IID_TXE);

   tx_empty_tracker #(.DELAY(TXE_DELAY)) u_txe (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_empty (tx_empty),
      .tx_write (tx_write),
      .char_tick(char_tick),
      .ack_read (txe_ack),
      .pending  (txe_pend)
   );

   irq_resolver u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .ien     (ien),
      .src_line(line_q),
      .src_data(data_avail),
      .src_idle(idle_to),
      .src_txe (txe_pend),
      .iir_read(iir_read),
      .iir_code(iir_code)
   );

   assign irq = ~iir_code[0];
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ien = '0;
   logic [3:0] rx_err = '0;
   logic [4:0] rx_count = '0;
   logic       rx_push = 1'b0;
   logic       rx_pop = 1'b0;
   logic [1:0] trig_sel = '0;
   logic       char_tick = 1'b0;
   logic       tx_empty = 1'b1;
   logic       tx_write = 1'b0;
   logic       iir_read = 1'b0;
   logic       lsr_read = 1'b0;
   logic       irq;
   logic [3:0] iir_code;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_irq_ident u_dut (
      .clk(clk), .rst_n(rst_n), .ien(ien), .rx_err(rx_err),
      .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop),
      .trig_sel(trig_sel), .char_tick(char_tick), .tx_empty(tx_empty),
      .tx_write(tx_write), .iir_read(iir_read), .lsr_read(lsr_read),
      .irq(irq), .iir_code(iir_code)
   );

   // reference model state
   bit       m_line, m_empty_d, m_multi, m_arm, m_pend;
   int       m_idle;
   logic [3:0] m_code;

   function automatic int level_of(logic [1:0] s);
      case (s)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 14;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_line = 0; m_empty_d = 0; m_multi = 0; m_arm = 0; m_pend = 0;
         m_idle = 0; m_code = 4'b0001;
      end else begin
         bit data, idle, rise, done, fire, clr;
         logic [3:0] nxt;
         data = (int'(rx_count) >= level_of(trig_sel));
         idle = (m_idle == 4);
         if (m_line && ien[2])      nxt = 4'b0110;
         else if (data && ien[0])   nxt = 4'b0100;
         else if (idle && ien[0])   nxt = 4'b1100;
         else if (m_pend && ien[1]) nxt = 4'b0010;
         else                       nxt = 4'b0001;
         clr  = tx_write || (iir_read && m_code == 4'b0010);
         rise = tx_empty && !m_empty_d;
         done = m_arm && tx_empty && char_tick;
         fire = (rise && m_multi) || done;
         m_pend = (m_pend || fire) && !clr;
         if (tx_write || !tx_empty) m_arm = 0;
         else if (rise && !m_multi) m_arm = 1;
         else if (done) m_arm = 0;
         if (tx_write && !tx_empty) m_multi = 1;
         else if (rise && m_multi) m_multi = 0;
         m_empty_d = tx_empty;
         if (rx_push || rx_pop || rx_count == 0) m_idle = 0;
         else if (char_tick && m_idle < 4) m_idle++;
         m_line = (rx_err != 0) || (m_line && !lsr_read);
         if (!iir_read) m_code = nxt;
      end
   end

   function automatic string tag_of(logic [3:0] c);
      case (c)
         4'b0110: return "R4";
         4'b0100: return "R3";
         4'b1100: return "R6";
         4'b0010: return "R7";
         default: return "R1";
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (iir_code !== m_code || irq !== ~m_code[0]) begin
            errors++;
            $display("FAIL %s model compare: code=%b irq=%b expected code=%b irq=%b",
                     tag_of(m_code), iir_code, irq, m_code, ~m_code[0]);
         end
      end
   end

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         errors++;
         $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic expect_code(logic [3:0] exp, string req);
      checks++;
      if (iir_code !== exp || irq !== ~exp[0]) begin
         errors++;
         $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
                  req, iir_code, irq, exp, ~exp[0]);
      end
   endtask

   task automatic tick();
      char_tick = 1'b1; step(1); char_tick = 1'b0; step(1);
   endtask

   initial begin
      step(2);
      rst_n = 1'b1;
      step(1);
      expect_code(4'b0001, "R1");

      // R3 trigger comparisons, R5 gating
      ien = 3'b111; trig_sel = 2'b01; rx_count = 5'd3;
      rx_push = 1'b1; step(1); rx_push = 1'b0; step(1);
      expect_code(4'b0001, "R3");
      rx_count = 5'd4; step(1);
      expect_code(4'b0100, "R3");
      rx_count = 5'd3; step(1);
      expect_code(4'b0001, "R3");
      trig_sel = 2'b11; rx_count = 5'd13; step(1);
      expect_code(4'b0001, "R3");
      rx_count = 5'd14; step(1);
      expect_code(4'b0100, "R3");
      trig_sel = 2'b00; rx_count = 5'd1; step(1);
      expect_code(4'b0100, "R3");
      ien = 3'b110; step(1);
      expect_code(4'b0001, "R5");

      // R6 character time-out
      ien = 3'b001; trig_sel = 2'b11; rx_count = 5'd2;
      rx_push = 1'b1; step(1); rx_push = 1'b0; step(1);
      tick(); tick(); tick();
      expect_code(4'b0001, "R6");
      tick();
      expect_code(4'b1100, "R6");
      rx_pop = 1'b1; rx_count = 5'd1; step(1); rx_pop = 1'b0; step(1);
      expect_code(4'b0001, "R6");

      // R4 line status over data available (R2)
      ien = 3'b111; rx_count = 5'd14;
      rx_err = 4'b0100; step(1); rx_err = 4'b0000; step(1);
      expect_code(4'b0110, "R2");
      lsr_read = 1'b1; step(1); lsr_read = 1'b0; step(1);
      expect_code(4'b0100, "R4");
      rx_count = 5'd0; step(1);
      // start-up delayed holding-empty fired during the ticks above, gated off then
      ien = 3'b010; step(1);
      expect_code(4'b0010, "R8");

      // R9 read-clear of holding empty, R10 hold during read
      iir_read = 1'b1; step(1);
      expect_code(4'b0010, "R10");
      iir_read = 1'b0; step(1);
      expect_code(4'b0001, "R9");

      // R8 single character: delayed until a tick
      tx_write = 1'b1; step(1); tx_write = 1'b0; tx_empty = 1'b0; step(2);
      tx_empty = 1'b1; step(3);
      expect_code(4'b0001, "R8");
      tick();
      expect_code(4'b0010, "R8");
      tx_write = 1'b1; step(1); tx_write = 1'b0; tx_empty = 1'b0; step(1);
      expect_code(4'b0001, "R9");

      // R7 two characters held: immediate
      tx_write = 1'b1; step(1); tx_write = 1'b0; step(2);
      tx_empty = 1'b1; step(2);
      expect_code(4'b0010, "R7");

      // R10 event during a long read is deferred
      ien = 3'b111;
      iir_read = 1'b1; step(1);
      rx_err = 4'b0001; step(1); rx_err = 4'b0000; step(2);
      expect_code(4'b0010, "R10");
      iir_read = 1'b0; step(1);
      expect_code(4'b0110, "R10");
      lsr_read = 1'b1; step(1); lsr_read = 1'b0; step(1);
      expect_code(4'b0001, "R9");

      step(5);
      finish_run();
   end
endmodule